// File: doc/BRIEF.md
# SDLC Frame Transmitter with Automatic RTS

This block turns bytes written by a host into bit-oriented synchronous frames on a single serial line. The host pushes bytes into a small transmit FIFO. When the transmitter is idle and data is waiting, it starts a frame without further host action. Each frame begins with a flag, carries the queued bytes with zero-bit insertion, and ends with a 16-bit frame check sequence and a second flag. The frame ends as soon as the FIFO is empty at a byte boundary.

The line can be sent as plain NRZ or as NRZI. The block drives an active-low request-to-send output. This output goes low as soon as the host writes while the line is idle, and it returns high on its own once the closing flag has left. When a frame finishes, the block sets an end-of-message latch and raises a one-cycle interrupt pulse. The latch clears by itself when the next frame starts. Serial timing comes from a bit-enable strobe supplied by the surrounding clocking logic, which pulses at most once every four system clocks.

Top module: `sdlc_frame_tx`

## Requirements
- R1: The FIFO holds 4 bytes. `fifo_full` is high while 4 bytes are queued, and a write made while full is dropped: a burst of 5 writes into an idle, empty block transmits only the first 4 bytes.
- R2: `rts_n` goes low on the clock edge that accepts a write while the transmitter is idle, and it stays low for every bit of the frame that follows.
- R3: The bit-enable that finds data waiting in idle starts the frame. From the next bit-enable on, an opening flag 0x7E goes out, least significant bit first, so the line carries 0,1,1,1,1,1,1,0 in that order.
- R4: Data bytes go out least significant bit first. After any five consecutive 1 bits in the data or the check sequence, a 0 is inserted. Flag bits are never stuffed.
- R5: When the FIFO is empty after a byte, the check sequence follows: CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, computed over the data bits, complemented and sent least significant bit first. The closing flag 0x7E then follows.
- R6: On the bit-enable that follows the last closing-flag bit, `rts_n` returns high and `txd` is driven high.
- R7: On that same edge `eom_latch` is set and `tx_irq` pulses high for one clock. `eom_latch` clears on the bit-enable that starts the next frame.
- R8: With `nrzi_en` high, each line bit toggles `txd` for a 0 and holds it for a 1. Encoding starts from the high idle level, and the line is forced high after the frame.
- R9: `txd` changes only on clock edges where `bit_en` is high, and it rests high whenever no frame is in progress.
- R10: After reset: `txd`=1, `rts_n`=1, `fifo_full`=0, `eom_latch`=0, `tx_irq`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte to queue |
| fifo_full | output | 1 | Transmit FIFO holds its maximum number of bytes |
| nrzi_en | input | 1 | Select NRZI line coding (held steady during a frame) |
| bit_en | input | 1 | Serial bit strobe, at most one per four clocks |
| txd | output | 1 | Serial transmit data |
| rts_n | output | 1 | Active-low request to send |
| eom_latch | output | 1 | End-of-message / underrun status |
| tx_irq | output | 1 | One-cycle pulse when a frame has fully left |

## Verification
The assertions take for granted that `bit_en` never pulses twice within four clocks. They also assume that `nrzi_en` stays constant while a frame is on the line, because the hold-between-strobes and idle-level properties rely on both. The stimulus produces `bit_en` from a divide-by-four counter that restarts at zero each time it is enabled. Every capture is followed by several quiet clocks before the next frame, so the strobe spacing holds even across stop and restart. `nrzi_en` and host writes are changed only while the strobe generator is off.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

  localparam int          CRC_W     = 16;
  localparam logic [15:0] CRC_POLY  = 16'h8408;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;
  localparam logic [7:0]  FLAG_PAT  = 8'h7E;
  localparam int          MAX_ONES  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_TAIL
  } tx_state_e;

  // one serial step of the reflected CRC-16
  function automatic logic [15:0] crc_step(input logic [15:0] crc, input logic b);
    logic [15:0] nxt;
    nxt = crc >> 1;
    if (crc[0] ^ b) nxt = nxt ^ CRC_POLY;
    return nxt;
  endfunction

endpackage

// File: rtl/sdlc_tx_fifo.sv
module sdlc_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign level   = count;
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sdlc_tx_framer.sv
module sdlc_tx_framer
  import sdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SH_W  = (CRC_W > DATA_W) ? CRC_W : DATA_W,
  localparam int CNT_W = $clog2(SH_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              host_wr,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_dout,
  output logic              fifo_pop,
  output logic              line_valid,
  output logic              line_bit,
  output logic              line_mark,
  output logic              tx_active,
  output logic              frame_start,
  output logic [2:0]        ones_run,
  output logic              rts_n,
  output logic              eom_latch,
  output logic              tx_irq
);

  tx_state_e        state;
  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       ones;
  logic [15:0]      crc;

  logic emit, stuff_now, shift_now, last_bit, cur_bit, flag_phase, tail_done;
  logic [15:0] crc_nxt;

  assign emit       = bit_en && (state inside {ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE});
  assign stuff_now  = emit && (ones == 3'(MAX_ONES));
  assign shift_now  = emit && !stuff_now;
  assign cur_bit    = sh[0];
  assign last_bit   = shift_now && (cnt == CNT_W'(1));
  assign flag_phase = (state == ST_OPEN) || (state == ST_CLOSE);
  assign crc_nxt    = (state == ST_DATA) ? crc_step(crc, cur_bit) : crc;
  assign tail_done  = bit_en && (state == ST_TAIL);

  assign frame_start = bit_en && (state == ST_IDLE) && !fifo_empty;
  assign fifo_pop    = last_bit && (state inside {ST_OPEN, ST_DATA}) && !fifo_empty;
  assign line_valid  = emit;
  assign line_bit    = stuff_now ? 1'b0 : cur_bit;
  assign line_mark   = tail_done;
  assign tx_active   = (state != ST_IDLE);
  assign ones_run    = ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sh        <= '0;
      cnt       <= '0;
      ones      <= '0;
      crc       <= CRC_SEED;
      rts_n     <= 1'b1;
      eom_latch <= 1'b0;
      tx_irq    <= 1'b0;
    end else begin
      tx_irq <= 1'b0;

      if (frame_start) begin
        state     <= ST_OPEN;
        sh        <= SH_W'(FLAG_PAT);
        cnt       <= CNT_W'(8);
        ones      <= '0;
        crc       <= CRC_SEED;
        eom_latch <= 1'b0;
      end

      if (stuff_now) ones <= '0;

      if (shift_now) begin
        sh  <= sh >> 1;
        cnt <= cnt - 1'b1;
        crc <= crc_nxt;
        if (flag_phase)   ones <= '0;
        else if (cur_bit) ones <= ones + 1'b1;
        else              ones <= '0;

        if (last_bit) begin
          unique case (state)
            ST_OPEN, ST_DATA: begin
              if (!fifo_empty) begin
                sh    <= SH_W'(fifo_dout);
                cnt   <= CNT_W'(DATA_W);
                state <= ST_DATA;
              end else begin
                sh    <= SH_W'(~crc_nxt);
                cnt   <= CNT_W'(CRC_W);
                state <= ST_FCS;
              end
            end
            ST_FCS: begin
              sh    <= SH_W'(FLAG_PAT);
              cnt   <= CNT_W'(8);
              state <= ST_CLOSE;
            end
            ST_CLOSE: state <= ST_TAIL;
            default:  state <= state;
          endcase
        end
      end

      if (tail_done) begin
        state     <= ST_IDLE;
        rts_n     <= 1'b1;
        eom_latch <= 1'b1;
        tx_irq    <= 1'b1;
      end else if ((state == ST_IDLE) && (host_wr || !fifo_empty)) begin
        rts_n <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdlc_tx_line.sv
module sdlc_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic nrzi_en,
  input  logic line_valid,
  input  logic line_bit,
  input  logic line_mark,
  output logic txd
);

  logic level_q;

  function automatic logic next_level(input logic cur, input logic b, input logic nrzi);
    if (!nrzi) return b;
    return b ? cur : ~cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          level_q <= 1'b1;
    else if (line_mark)  level_q <= 1'b1;
    else if (line_valid) level_q <= next_level(level_q, line_bit, nrzi_en);
  end

  assign txd = level_q;

endmodule

// File: rtl/sdlc_frame_tx.sv
module sdlc_frame_tx #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fifo_full,
  input  logic              nrzi_en,
  input  logic              bit_en,
  output logic              txd,
  output logic              rts_n,
  output logic              eom_latch,
  output logic              tx_irq
);

  logic              fifo_empty, fifo_pop;
  logic [DATA_W-1:0] fifo_dout;
  logic [LVL_W-1:0]  fifo_level;
  logic              line_valid, line_bit, line_mark;
  logic              tx_active, frame_start;
  logic [2:0]        ones_run;

  sdlc_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_en),
    .din   (wr_data),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full),
    .level (fifo_level)
  );

  sdlc_tx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .host_wr     (wr_en),
    .fifo_empty  (fifo_empty),
    .fifo_dout   (fifo_dout),
    .fifo_pop    (fifo_pop),
    .line_valid  (line_valid),
    .line_bit    (line_bit),
    .line_mark   (line_mark),
    .tx_active   (tx_active),
    .frame_start (frame_start),
    .ones_run    (ones_run),
    .rts_n       (rts_n),
    .eom_latch   (eom_latch),
    .tx_irq      (tx_irq)
  );

  sdlc_tx_line u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .nrzi_en    (nrzi_en),
    .line_valid (line_valid),
    .line_bit   (line_bit),
    .line_mark  (line_mark),
    .txd        (txd)
  );

endmodule

// File: rtl/sdlc_frame_tx_chk.sv
module sdlc_frame_tx_chk #(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             bit_en,
  input logic             txd,
  input logic             rts_n,
  input logic             eom_latch,
  input logic             tx_irq,
  input logic             fifo_full,
  input logic [LVL_W-1:0] fifo_level,
  input logic             tx_active,
  input logic             frame_start,
  input logic [2:0]       ones_run
);

  // input contract: strobe spacing of at least four clocks (R9)
  p_bit_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> (!$past(bit_en, 1) && !$past(bit_en, 2) && !$past(bit_en, 3)));

  p_txd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd));

  p_idle_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> txd);

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !bit_en) |=> fifo_full);

  p_rts_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !rts_n);

  p_stuff_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ones_run <= 3'd5);

  p_rts_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> (!tx_active && txd && eom_latch));

  p_eom_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !eom_latch);

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (eom_latch && $rose(eom_latch)));

endmodule

bind sdlc_frame_tx sdlc_frame_tx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .bit_en      (bit_en),
  .txd         (txd),
  .rts_n       (rts_n),
  .eom_latch   (eom_latch),
  .tx_irq      (tx_irq),
  .fifo_full   (fifo_full),
  .fifo_level  (fifo_level),
  .tx_active   (tx_active),
  .frame_start (frame_start),
  .ones_run    (ones_run)
);

// File: tb/sdlc_frame_tx_bench.sv
`timescale 1ns/1ps
module sdlc_frame_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       nrzi_en = 1'b0;
  logic       bit_en = 1'b0;
  logic       fifo_full, txd, rts_n, eom_latch, tx_irq;

  always #2 clk = ~clk;

  sdlc_frame_tx u_sdlc_frame_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_full(fifo_full), .nrzi_en(nrzi_en), .bit_en(bit_en),
    .txd(txd), .rts_n(rts_n), .eom_latch(eom_latch), .tx_irq(tx_irq)
  );

  int checks = 0;
  int fails  = 0;

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // capture and strobe generation, all at the falling edge
  logic gen_on = 1'b0, cap_on = 1'b0, cap_done = 1'b0;
  logic [1:0] div = 2'd0;
  logic raw_txd [0:255];
  logic raw_rts [0:255];
  logic raw_eom [0:255];
  int   ns = 0;
  int   hold_viol = 0;
  int   irq_cnt = 0;
  logic prev_txd = 1'b1;

  always @(negedge clk) begin
    if (cap_on && bit_en) begin
      raw_txd[ns] = txd;
      raw_rts[ns] = rts_n;
      raw_eom[ns] = eom_latch;
      ns++;
      if (rts_n || ns >= 255) begin
        cap_on   = 1'b0;
        cap_done = 1'b1;
      end
    end
    if (rst_n && !bit_en && txd !== prev_txd) hold_viol++;
    prev_txd = txd;
    if (tx_irq) irq_cnt++;
    if (gen_on) begin
      div    = div + 2'd1;
      bit_en = (div == 2'd3);
    end else begin
      div    = 2'd0;
      bit_en = 1'b0;
    end
  end

  function automatic logic [15:0] fcs_of(input logic [39:0] b, input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {8'h00, b[8*k +: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic run_frame(input logic nz, input int nw, input logic [39:0] bytes);
    int   n, s, e, nd, ones, stuff_err, exp_len, irq_before;
    logic nrz [0:255];
    logic dbits [0:127];
    logic prev;
    logic [15:0] fcs;
    logic [7:0]  got;
    n = (nw > 4) ? 4 : nw;
    nrzi_en = nz;
    for (int i = 0; i < nw; i++) begin
      wr_en = 1'b1;
      wr_data = bytes[8*i +: 8];
      @(negedge clk);
      if (i == 0) expect_eq("R2", "rts_n after first write", rts_n, 0);
    end
    wr_en = 1'b0;
    expect_eq("R1", "fifo_full after writes", fifo_full, (n == 4) ? 1 : 0);
    irq_before = irq_cnt;
    ns = 0; cap_done = 1'b0; cap_on = 1'b1; gen_on = 1'b1;
    while (!cap_done) @(negedge clk);
    gen_on = 1'b0;
    repeat (8) @(negedge clk);

    // line decode
    prev = 1'b1;
    for (int i = 0; i < ns; i++) begin
      nrz[i] = nz ? (raw_txd[i] == prev) : raw_txd[i];
      prev = raw_txd[i];
    end
    e = ns - 1;
    s = -1;
    for (int i = 0; i < e; i++) if (s < 0 && nrz[i] == 1'b0) s = i;
    expect_eq("R3", "flag starts one strobe after start", s, 1);
    if (s < 0 || e - s < 16) begin
      expect_eq("R6", "frame too short", e - s, 16);
      return;
    end
    got = '0;
    for (int k = 0; k < 8; k++) got[k] = nrz[s + k];
    expect_eq("R3", "opening flag", got, 8'h7E);
    got = '0;
    for (int k = 0; k < 8; k++) got[k] = nrz[e - 8 + k];
    expect_eq("R5", "closing flag", got, 8'h7E);

    // destuff the body
    nd = 0; ones = 0; stuff_err = 0;
    for (int i = s + 8; i < e - 8; i++) begin
      if (ones == 5) begin
        if (nrz[i] != 1'b0) stuff_err++;
        ones = 0;
      end else begin
        if (nd < 128) dbits[nd] = nrz[i];
        nd++;
        ones = nrz[i] ? ones + 1 : 0;
      end
    end
    expect_eq("R4", "inserted bits are zero", stuff_err, 0);
    expect_eq("R4", "body bit count", nd, 8 * (n + 2));
    fcs = fcs_of(bytes, n);
    if (nd == 8 * (n + 2)) begin
      for (int k = 0; k < n + 2; k++) begin
        got = '0;
        for (int j = 0; j < 8; j++) got[j] = dbits[8*k + j];
        if (k < n) expect_eq(nz ? "R8" : "R4", "data byte", got, bytes[8*k +: 8]);
        else expect_eq("R5", "check byte", got, fcs[8*(k-n) +: 8]);
      end
    end

    // expected stuffed length from the requirements
    ones = 0; exp_len = 16;
    for (int k = 0; k < 8 * (n + 2); k++) begin
      logic b;
      b = (k < 8 * n) ? bytes[k] : fcs[k - 8 * n];
      exp_len++;
      ones = b ? ones + 1 : 0;
      if (ones == 5) begin exp_len++; ones = 0; end
    end
    expect_eq("R6", "rts_n release right after closing flag", e - s, exp_len);
    prev = 1'b0;
    for (int i = 0; i < e; i++) if (raw_rts[i]) prev = 1'b1;
    expect_eq("R2", "rts_n low through frame", prev, 0);
    expect_eq(nz ? "R8" : "R6", "txd high at release", raw_txd[e], 1);
    expect_eq("R7", "eom cleared at frame start", raw_eom[0], 0);
    expect_eq("R7", "eom set after frame", eom_latch, 1);
    expect_eq("R7", "one irq pulse", irq_cnt - irq_before, 1);
    expect_eq("R9", "txd idle high", txd, 1);
  endtask

  // {nrzi, write count, bytes (byte 0 lowest)}
  localparam logic [47:0] VECS [6] = '{
    {4'd0, 4'd1, 40'h00_0000_0055},
    {4'd0, 4'd2, 40'h00_0000_FFFF},
    {4'd1, 4'd3, 40'h00_00A5_007E},
    {4'd1, 4'd4, 40'h00_FF1F_F83F},
    {4'd0, 4'd4, 40'h00_0403_0201},
    {4'd1, 4'd1, 40'h00_0000_00FF}
  };

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R10", "txd", txd, 1);
    expect_eq("R10", "rts_n", rts_n, 1);
    expect_eq("R10", "fifo_full", fifo_full, 0);
    expect_eq("R10", "eom_latch", eom_latch, 0);
    expect_eq("R10", "tx_irq", tx_irq, 0);

    for (int v = 0; v < 6; v++)
      run_frame(VECS[v][44], int'(VECS[v][43:40]), VECS[v][39:0]);

    // R1: fifth write into a full FIFO is dropped
    run_frame(1'b0, 5, 40'hEE_C3_81_7F_10);
    // back-to-back frame with the latch still set from before
    run_frame(1'b1, 2, 40'h00_0000_F00F);

    expect_eq("R9", "txd changed without strobe", hold_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule